// File: doc/BRIEF.md
# Pin Boundary-Scan Chain

This block places a serial scan chain between the core logic and the pads of a parameterised group of bidirectional pins. Each pin owns three scan cells: one for the pad output enable, one for the pad output value and one for the pad input value. Every cell has a shift stage, which sits on the serial path, and an update stage, which holds the value that can be driven towards the pad or the core. A test access port controller outside the block supplies the capture, shift and update strobes and a three-bit code for the current instruction. The block does not contain that controller or the instruction register.

The instruction code controls both the serial path and the pad multiplexers. Under sample/preload, the chain captures and shifts while the pads and the core keep working normally. This lets test data be staged ahead of use. Under external test and clamp, the update stages drive the pads and feed the core. The change happens in the same cycle the instruction code changes, so staged data reaches the pins as soon as the new instruction becomes current. Under high-impedance, every pad driver is switched off. The serial output is flagged valid only while the chain is the selected scan path.

Top module: `bscan_pins`

## Requirements
- R1: A synchronous active-high reset clears every shift stage on the rising edge and every update stage on the falling edge. After reset, under external test, all pad enables and pad outputs read 0.
- R2: Chain order: cell 3k holds the enable of pin k, cell 3k+1 holds its output value and cell 3k+2 holds its input value. `tdo` shows cell 0, and `tdi` enters cell 3N-1.
- R3: When the chain is selected and `capture_dr` is high at a rising edge, cells 3k, 3k+1 and 3k+2 load `core_oe[k]`, `core_out[k]` and `pad_in[k]`. Capture takes priority over shift.
- R4: When the chain is selected and `shift_dr` is high (and `capture_dr` low) at a rising edge, every cell takes the value of the cell above it. Cell 3N-1 takes `tdi`, so cell 0 moves out towards `tdo`.
- R5: When the chain is selected and `update_dr` is high at a falling edge, every update stage copies its shift stage.
- R6: The chain is selected only for codes 000 (external test) and 001 (sample/preload). For any other code, the capture, shift and update strobes leave both stages unchanged.
- R7: Under code 001, code 111 (bypass) and the unassigned codes 100, 101 and 110, `pad_oe` = `core_oe`, `pad_out` = `core_out` and `core_in` = `pad_in`.
- R8: Under code 000, `pad_oe[k]`, `pad_out[k]` and `core_in[k]` take the update stages of cells 3k, 3k+1 and 3k+2. This takes effect in the same cycle the code is applied.
- R9: Code 010 (clamp) drives the pads and the core from the update stages in the same way as R8, while the chain stays deselected.
- R10: Under code 011 (high impedance), all `pad_oe` and `pad_out` bits are 0 and `core_in` = `pad_in`.
- R11: `tdo_valid` is high exactly when the code is 000 or 001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock; shift stages use the rising edge, update stages the falling edge |
| rst | input | 1 | Synchronous active-high reset |
| capture_dr | input | 1 | Capture strobe from the controller |
| shift_dr | input | 1 | Shift strobe from the controller |
| update_dr | input | 1 | Update strobe from the controller |
| op | input | 3 | Current instruction code |
| tdi | input | 1 | Serial test data in |
| core_out | input | N_PINS | Output values from core logic |
| core_oe | input | N_PINS | Output enables from core logic |
| pad_in | input | N_PINS | Values received at the pads |
| pad_out | output | N_PINS | Value driven to each pad |
| pad_oe | output | N_PINS | Driver enable for each pad |
| core_in | output | N_PINS | Input values presented to core logic |
| tdo | output | 1 | Serial test data out (cell 0) |
| tdo_valid | output | 1 | Chain is the active scan path |

## Verification
A faulty shift stage shows up on `tdo` within the cycles needed to shift its position down to cell 0. Up to 3N rising edges after a capture, every captured bit has left the chain. A faulty update stage is invisible while the code selects core drive. It appears on `pad_oe`, `pad_out` or `core_in` in the same cycle external test or clamp is applied. A strobe that leaks through while the chain is deselected shows up later: as a changed `tdo` once the chain is selected again, or as changed pad values under external test.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

    localparam int CELLS_PER_PIN = 3;
    localparam int OP_W          = 3;

    localparam logic [OP_W-1:0] OP_EXTEST = 3'b000;
    localparam logic [OP_W-1:0] OP_SAMPLE = 3'b001;
    localparam logic [OP_W-1:0] OP_CLAMP  = 3'b010;
    localparam logic [OP_W-1:0] OP_HIGHZ  = 3'b011;
    localparam logic [OP_W-1:0] OP_BYPASS = 3'b111;

    typedef struct packed {
        logic cap;
        logic shf;
        logic upd;
    } strobe_t;

    typedef struct packed {
        logic oe;
        logic dout;
        logic din;
    } pin_bits_t;

    typedef struct packed {
        logic scan_sel;
        logic use_latch;
        logic force_off;
    } route_t;

    function automatic logic op_scans(input logic [OP_W-1:0] code);
        return (code == OP_EXTEST) || (code == OP_SAMPLE);
    endfunction

    function automatic logic op_latch_drive(input logic [OP_W-1:0] code);
        return (code == OP_EXTEST) || (code == OP_CLAMP);
    endfunction

    function automatic logic op_drivers_off(input logic [OP_W-1:0] code);
        return code == OP_HIGHZ;
    endfunction

endpackage

// File: rtl/bscan_cell.sv
module bscan_cell
    import bscan_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  strobe_t strb,
    input  logic    pi,
    input  logic    si,
    output logic    so,
    output logic    po
);

    logic shift_q;
    logic hold_q;

    always_ff @(posedge clk) begin
        if (rst)
            shift_q <= 1'b0;
        else if (strb.cap)
            shift_q <= pi;
        else if (strb.shf)
            shift_q <= si;
    end

    always_ff @(negedge clk) begin
        if (rst)
            hold_q <= 1'b0;
        else if (strb.upd)
            hold_q <= shift_q;
    end

    assign so = shift_q;
    assign po = hold_q;

endmodule

// File: rtl/bscan_pin.sv
module bscan_pin
    import bscan_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  strobe_t   strb,
    input  pin_bits_t sys,
    input  logic      si,
    output pin_bits_t sh,
    output pin_bits_t lat
);

    logic [CELLS_PER_PIN-1:0] pi_v;
    logic [CELLS_PER_PIN-1:0] si_v;
    logic [CELLS_PER_PIN-1:0] so_v;
    logic [CELLS_PER_PIN-1:0] po_v;

    assign pi_v[0] = sys.oe;
    assign pi_v[1] = sys.dout;
    assign pi_v[2] = sys.din;

    for (genvar c = 0; c < CELLS_PER_PIN; c++) begin : g_cell
        if (c == CELLS_PER_PIN - 1) begin : g_top
            assign si_v[c] = si;
        end else begin : g_link
            assign si_v[c] = so_v[c+1];
        end
        bscan_cell u_cell (
            .clk  (clk),
            .rst  (rst),
            .strb (strb),
            .pi   (pi_v[c]),
            .si   (si_v[c]),
            .so   (so_v[c]),
            .po   (po_v[c])
        );
    end

    assign sh.oe    = so_v[0];
    assign sh.dout  = so_v[1];
    assign sh.din   = so_v[2];
    assign lat.oe   = po_v[0];
    assign lat.dout = po_v[1];
    assign lat.din  = po_v[2];

endmodule

// File: rtl/bscan_ctrl.sv
module bscan_ctrl
    import bscan_pkg::*;
(
    input  logic [OP_W-1:0] op,
    input  logic            capture_dr,
    input  logic            shift_dr,
    input  logic            update_dr,
    output strobe_t         strb,
    output route_t          route
);

    always_comb begin
        route.scan_sel  = op_scans(op);
        route.use_latch = op_latch_drive(op);
        route.force_off = op_drivers_off(op);
        strb.cap = capture_dr & route.scan_sel;
        strb.shf = shift_dr & ~capture_dr & route.scan_sel;
        strb.upd = update_dr & route.scan_sel;
    end

endmodule

// File: rtl/bscan_padmux.sv
module bscan_padmux
    import bscan_pkg::*;
#(
    parameter int N_PINS = 4
) (
    input  route_t            route,
    input  logic [N_PINS-1:0] core_out,
    input  logic [N_PINS-1:0] core_oe,
    input  logic [N_PINS-1:0] pad_in,
    input  logic [N_PINS-1:0] lat_out,
    input  logic [N_PINS-1:0] lat_oe,
    input  logic [N_PINS-1:0] lat_in,
    output logic [N_PINS-1:0] pad_out,
    output logic [N_PINS-1:0] pad_oe,
    output logic [N_PINS-1:0] core_in
);

    always_comb begin
        if (route.force_off) begin
            pad_out = '0;
            pad_oe  = '0;
            core_in = pad_in;
        end else if (route.use_latch) begin
            pad_out = lat_out;
            pad_oe  = lat_oe;
            core_in = lat_in;
        end else begin
            pad_out = core_out;
            pad_oe  = core_oe;
            core_in = pad_in;
        end
    end

endmodule

// File: rtl/bscan_pins.sv
module bscan_pins
    import bscan_pkg::*;
#(
    parameter int N_PINS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic              update_dr,
    input  logic [2:0]        op,
    input  logic              tdi,
    input  logic [N_PINS-1:0] core_out,
    input  logic [N_PINS-1:0] core_oe,
    input  logic [N_PINS-1:0] pad_in,
    output logic [N_PINS-1:0] pad_out,
    output logic [N_PINS-1:0] pad_oe,
    output logic [N_PINS-1:0] core_in,
    output logic              tdo,
    output logic              tdo_valid
);

    localparam int CHAIN_LEN = N_PINS * CELLS_PER_PIN;

    strobe_t   strb;
    route_t    route;
    pin_bits_t sys_a [N_PINS];
    pin_bits_t sh_a  [N_PINS];
    pin_bits_t lat_a [N_PINS];
    logic [N_PINS:0]        link;
    logic [N_PINS-1:0]      lat_out;
    logic [N_PINS-1:0]      lat_oe;
    logic [N_PINS-1:0]      lat_in;
    logic [CHAIN_LEN-1:0]   sh_vec;

    bscan_ctrl u_ctrl (
        .op         (op),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .update_dr  (update_dr),
        .strb       (strb),
        .route      (route)
    );

    assign link[N_PINS] = tdi;

    for (genvar k = 0; k < N_PINS; k++) begin : g_pin
        assign sys_a[k].oe   = core_oe[k];
        assign sys_a[k].dout = core_out[k];
        assign sys_a[k].din  = pad_in[k];

        bscan_pin u_pin (
            .clk  (clk),
            .rst  (rst),
            .strb (strb),
            .sys  (sys_a[k]),
            .si   (link[k+1]),
            .sh   (sh_a[k]),
            .lat  (lat_a[k])
        );

        assign link[k]  = sh_a[k].oe;
        assign lat_oe[k]  = lat_a[k].oe;
        assign lat_out[k] = lat_a[k].dout;
        assign lat_in[k]  = lat_a[k].din;
        assign sh_vec[CELLS_PER_PIN*k]     = sh_a[k].oe;
        assign sh_vec[CELLS_PER_PIN*k + 1] = sh_a[k].dout;
        assign sh_vec[CELLS_PER_PIN*k + 2] = sh_a[k].din;
    end

    bscan_padmux #(.N_PINS(N_PINS)) u_mux (
        .route    (route),
        .core_out (core_out),
        .core_oe  (core_oe),
        .pad_in   (pad_in),
        .lat_out  (lat_out),
        .lat_oe   (lat_oe),
        .lat_in   (lat_in),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe),
        .core_in  (core_in)
    );

    assign tdo       = link[0];
    assign tdo_valid = route.scan_sel;

endmodule

// File: rtl/bscan_pins_chk.sv
module bscan_pins_chk #(
    parameter int N_PINS = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  capture_dr,
    input logic                  shift_dr,
    input logic [2:0]            op,
    input logic                  tdi,
    input logic [N_PINS-1:0]     core_oe,
    input logic [N_PINS-1:0]     pad_in,
    input logic [N_PINS-1:0]     pad_out,
    input logic [N_PINS-1:0]     pad_oe,
    input logic [N_PINS-1:0]     core_in,
    input logic [N_PINS-1:0]     lat_out,
    input logic [N_PINS-1:0]     lat_oe,
    input logic [N_PINS-1:0]     lat_in,
    input logic [3*N_PINS-1:0]   sh_vec
);

    localparam int W = 3 * N_PINS;

    logic scan;
    assign scan = (op == 3'b000) || (op == 3'b001);

    // R3: capture loads core enable and pad input into pin 0 cells
    p_capture_r3: assert property (@(posedge clk) disable iff (rst)
        (scan && capture_dr) |=> (sh_vec[0] == $past(core_oe[0])) && (sh_vec[2] == $past(pad_in[0])));

    // R4: one step toward tdo per shift edge
    p_shift_r4: assert property (@(posedge clk) disable iff (rst)
        (scan && shift_dr && !capture_dr) |=> (sh_vec == {$past(tdi), $past(sh_vec[W-1:1])}));

    // R6: deselected chain holds its shift stages
    p_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !scan |=> $stable(sh_vec));

    // R8: external test routes the update stages
    p_extest_r8: assert property (@(posedge clk) disable iff (rst)
        (op == 3'b000) |-> (pad_oe == lat_oe) && (pad_out == lat_out) && (core_in == lat_in));

    // R10: high impedance turns every driver off
    p_highz_r10: assert property (@(posedge clk) disable iff (rst)
        (op == 3'b011) |-> (pad_oe == '0) && (core_in == pad_in));

endmodule

bind bscan_pins bscan_pins_chk #(.N_PINS(N_PINS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .capture_dr (capture_dr),
    .shift_dr   (shift_dr),
    .op         (op),
    .tdi        (tdi),
    .core_oe    (core_oe),
    .pad_in     (pad_in),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .core_in    (core_in),
    .lat_out    (lat_out),
    .lat_oe     (lat_oe),
    .lat_in     (lat_in),
    .sh_vec     (sh_vec)
);

// File: tb/bscan_pins_test.sv
module bscan_pins_test;

    localparam int N = 4;
    localparam int W = 3 * N;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         capture_dr = 1'b0;
    logic         shift_dr = 1'b0;
    logic         update_dr = 1'b0;
    logic [2:0]   op = 3'b000;
    logic         tdi = 1'b0;
    logic [N-1:0] core_out = '0;
    logic [N-1:0] core_oe = '0;
    logic [N-1:0] pad_in = '0;
    logic [N-1:0] pad_out;
    logic [N-1:0] pad_oe;
    logic [N-1:0] core_in;
    logic         tdo;
    logic         tdo_valid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit ref_sh [W];
    bit ref_lt [W];

    bscan_pins #(.N_PINS(N)) uut (
        .clk(clk), .rst(rst), .capture_dr(capture_dr), .shift_dr(shift_dr),
        .update_dr(update_dr), .op(op), .tdi(tdi), .core_out(core_out),
        .core_oe(core_oe), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .core_in(core_in), .tdo(tdo), .tdo_valid(tdo_valid)
    );

    always #4 clk = ~clk;

    function automatic bit selected(input logic [2:0] c);
        return c == 3'b000 || c == 3'b001;
    endfunction

    // reference: shift stages on rising edge
    always @(posedge clk) begin
        if (rst) begin
            foreach (ref_sh[i]) ref_sh[i] = 0;
        end else if (selected(op) && capture_dr) begin
            for (int k = 0; k < N; k++) begin
                ref_sh[3*k]   = core_oe[k];
                ref_sh[3*k+1] = core_out[k];
                ref_sh[3*k+2] = pad_in[k];
            end
        end else if (selected(op) && shift_dr) begin
            for (int i = 0; i < W - 1; i++) ref_sh[i] = ref_sh[i+1];
            ref_sh[W-1] = tdi;
        end
    end

    // reference: update stages on falling edge
    always @(negedge clk) begin
        if (rst) begin
            foreach (ref_lt[i]) ref_lt[i] = 0;
        end else if (selected(op) && update_dr) begin
            foreach (ref_lt[i]) ref_lt[i] = ref_sh[i];
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the reference, between edges
    always @(posedge clk) begin
        #6;
        if (!rst && !done) begin
            logic [N-1:0] e_oe, e_out, e_in;
            string tag;
            for (int k = 0; k < N; k++) begin
                if (op == 3'b011) begin
                    e_oe[k] = 0; e_out[k] = 0; e_in[k] = pad_in[k];
                end else if (op == 3'b000 || op == 3'b010) begin
                    e_oe[k] = ref_lt[3*k]; e_out[k] = ref_lt[3*k+1]; e_in[k] = ref_lt[3*k+2];
                end else begin
                    e_oe[k] = core_oe[k]; e_out[k] = core_out[k]; e_in[k] = pad_in[k];
                end
            end
            case (op)
                3'b000:  tag = "R8 pads";
                3'b010:  tag = "R9 pads";
                3'b011:  tag = "R10 pads";
                default: tag = "R7 pads";
            endcase
            chk(tag, {pad_oe, pad_out, core_in}, {e_oe, e_out, e_in});
            chk("R2 R4 tdo", tdo, ref_sh[0]);
            chk("R11 tdo_valid", tdo_valid, selected(op));
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] cap_exp;
        logic [W-1:0] pre;
        logic         tdo_keep;
        pre = 12'hA5C;

        // R1: reset
        op = 3'b000;
        repeat (3) tick();
        rst = 0;
        tick();
        #4;
        chk("R1 reset pads", {pad_oe, pad_out, core_in}, '0);
        chk("R1 reset tdo", tdo, 1'b0);

        // R3 capture under sample/preload
        op = 3'b001;
        core_oe = 4'b1010; core_out = 4'b0110; pad_in = 4'b0011;
        for (int k = 0; k < N; k++) begin
            cap_exp[3*k] = core_oe[k]; cap_exp[3*k+1] = core_out[k]; cap_exp[3*k+2] = pad_in[k];
        end
        tick();
        capture_dr = 1;
        tick();
        capture_dr = 0;
        shift_dr = 1;
        // R2 R4: shift out captured bits while loading the preload pattern
        for (int s = 0; s < W; s++) begin
            #4;
            chk("R3 R4 captured bit at tdo", tdo, cap_exp[s]);
            tdi = pre[s];
            tick();
        end
        shift_dr = 0;
        update_dr = 1;
        tick();
        update_dr = 0;
        #4;
        // R7: sample/preload keeps core drive
        chk("R7 sample pads", {pad_oe, pad_out, core_in}, {core_oe, core_out, pad_in});
        tick();
        // R5 R8: preload appears immediately under external test
        op = 3'b000;
        #4;
        for (int k = 0; k < N; k++) begin
            chk("R5 R8 pad_oe", pad_oe[k], pre[3*k]);
            chk("R5 R8 pad_out", pad_out[k], pre[3*k+1]);
            chk("R8 core_in", core_in[k], pre[3*k+2]);
        end
        tick();
        // R9 clamp
        op = 3'b010;
        #4;
        chk("R9 clamp pad_out", pad_out, {pre[10], pre[7], pre[4], pre[1]});
        chk("R11 clamp tdo_valid", tdo_valid, 1'b0);
        tick();
        // R10 high impedance
        op = 3'b011;
        #4;
        chk("R10 highz pad_oe", pad_oe, '0);
        chk("R10 highz pad_out", pad_out, '0);
        tick();
        // R6: strobes ignored under bypass
        op = 3'b111;
        #4;
        tdo_keep = tdo;
        tick();
        capture_dr = 1; update_dr = 1;
        tick();
        capture_dr = 0; shift_dr = 1; tdi = 1;
        tick();
        shift_dr = 0; update_dr = 0;
        #4;
        chk("R6 bypass tdo held", tdo, tdo_keep);
        chk("R7 bypass pads", {pad_oe, pad_out}, {core_oe, core_out});
        tick();
        op = 3'b000;
        #4;
        chk("R6 latches held", pad_out, {pre[10], pre[7], pre[4], pre[1]});
        tick();
        // R3: capture wins over shift
        core_oe = 4'b0001;
        capture_dr = 1; shift_dr = 1;
        tick();
        capture_dr = 0; shift_dr = 0;
        #4;
        chk("R3 capture priority tdo", tdo, 1'b1);
        tick();

        // random traffic checked by the reference every cycle
        for (int n = 0; n < 600; n++) begin
            case ($urandom % 7)
                0: op = 3'b000;
                1: op = 3'b001;
                2: op = 3'b010;
                3: op = 3'b011;
                4: op = 3'b111;
                5: op = 3'b101;
                default: op = 3'b001;
            endcase
            capture_dr = ($urandom % 6) == 0;
            shift_dr   = ($urandom % 2) == 0;
            update_dr  = ($urandom % 5) == 0;
            tdi        = $urandom % 2;
            core_out   = $urandom;
            core_oe    = $urandom;
            pad_in     = $urandom;
            tick();
        end
        tick();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule